// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block times the serial clock and data lines for an I2C master. A bit engine above it hands over one command at a time (a bit slot, a START or a STOP) with a ready/valid handshake. The block then drives the open-drain controls for SCL and SDA, reports when the receive strobe fires and what level SDA had, and pulses a done flag when the command's last phase ends. All phase lengths come from a 32-bit timing word that holds four counts. A 3-bit prescaler sets how many functional-clock cycles make one timing tick.

Two timing words are present: a standard one and a high-speed one. A mode input chooses between them when a command is accepted. Both line inputs pass through a two-flop synchronizer and then a glitch filter whose width can be programmed. The filtered SCL gates the high phase, so a slave that holds SCL low stretches the clock. The filtered levels are also brought out for the bit engine.

Top module: `i2c_sclgen`

## Requirements
- R1: After reset, scl_drv_low and sda_drv_low are 0, cmd_ready is 1 and cmd_done is 0.
- R2: One tick lasts 2^presc clock cycles (presc 0..7), and every count is measured in ticks. For a bit slot, SCL is released exactly lo*2^presc cycles after the accepting edge. A count of 0 acts as 1 tick.
- R3: The SCL-low count is timing word bits [5:0]. Bits [7:6] are ignored, so the low count is always below 64. The high count is bits [15:8], the setup/hold count is bits [23:16] and the data-valid count is bits [31:24].
- R4: In a bit slot, sda_drv_low takes the value NOT cmd_bit exactly dv ticks after acceptance. It does so at SCL release at the latest, and at once if dv is 0.
- R5: After a bit slot releases SCL, the high count does not start until filtered SCL reads high on a tick. SCL is then driven low again, and cmd_done pulses, hi ticks later. While a slave holds SCL low, neither event happens.
- R6: In a bit slot, sda_sample pulses for one cycle on the tick where filtered SCL is first seen high. sample_bit then holds the filtered SDA level from that cycle.
- R7: START (cmd_op 01) while SCL is not owned drives SDA low at acceptance. It drives SCL low sh ticks later and pulses cmd_done.
- R8: START while SCL is owned (a repeated start) first releases SDA and then SCL after lo ticks. It waits for filtered SCL high, drives SDA low sh ticks later, and drives SCL low sh ticks after that.
- R9: STOP (cmd_op 10) drives SDA low at acceptance and releases SCL after lo ticks. Once filtered SCL is seen high, it waits sh ticks, then releases SDA and pulses cmd_done, leaving SCL released.
- R10: The SDA filter width is filter word bits [27:24] and the SCL width is bits [19:16]. With width 0 the filtered level follows the input 2 cycles later. With width W>0 a change appears 2+W cycles after the input changes, and a pulse shorter than W cycles never appears.
- R11: hs_mode=1 at acceptance makes the command use timing_hs, and hs_mode=0 makes it use timing_std.
- R12: A command is accepted only on a clock edge with cmd_valid and cmd_ready both high. cmd_valid while cmd_ready is low has no effect. Any cmd_op other than 01 or 10 is a bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 3 | Tick divider exponent |
| hs_mode | input | 1 | Select high-speed timing word |
| timing_std | input | 32 | Standard timing counts |
| timing_hs | input | 32 | High-speed timing counts |
| filt_cfg | input | 32 | Glitch filter widths |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 00/11 bit slot, 01 START, 10 STOP |
| cmd_bit | input | 1 | Bit to send (1 releases SDA) |
| cmd_ready | output | 1 | Idle, able to accept |
| cmd_done | output | 1 | One-cycle command completion pulse |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drv_low | output | 1 | Pull SCL low |
| sda_drv_low | output | 1 | Pull SDA low |
| scl_filt | output | 1 | Filtered SCL level |
| sda_filt | output | 1 | Filtered SDA level |
| sda_sample | output | 1 | Receive strobe pulse |
| sample_bit | output | 1 | SDA level captured at the strobe |

## Verification
The bench measures the cycle of every edge against the accepting clock edge. A prescaler that restarted late or counted one tick too many would move the SCL release off lo*2^presc. Holding SCL low from the slave side shows whether the high phase waits for the line or runs free; a design that ignored the line would end the slot while the slave still holds SCL. Repeated START and STOP are timed edge by edge, so swapped setup and hold phases or a missing wait for SCL high show up as shifted SDA edges. Short and long pulses on SDA test the filter threshold exactly at W-1 and the latency at 2+W.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

  localparam int SG_WORD_W     = 32;
  // timing word field positions (decoded by the sequencer)
  localparam int SG_HI_LSB     = 8;
  localparam int SG_SH_LSB     = 16;
  localparam int SG_DV_LSB     = 24;
  // filter word field positions
  localparam int SG_SCL_FW_LSB = 16;
  localparam int SG_SDA_FW_LSB = 24;

  typedef enum logic [1:0] {
    OP_BIT   = 2'b00,
    OP_START = 2'b01,
    OP_STOP  = 2'b10,
    OP_BIT_X = 2'b11
  } sg_op_e;

  typedef enum logic [2:0] {
    SG_IDLE,
    SG_LOW,
    SG_WAIT,
    SG_HIGH,
    SG_HOLD
  } sg_state_e;

  function automatic logic sg_is_bit(input sg_op_e op);
    return !(op == OP_START || op == OP_STOP);
  endfunction

endpackage

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0] pcnt;

  // low 'p' bits set: tick when they are all ones
  function automatic logic [PC_W-1:0] div_mask(input logic [PRE_W-1:0] p);
    logic [PC_W-1:0] m;
    m = '0;
    for (int i = 0; i < PC_W; i++) begin
      if (i < int'(p)) m[i] = 1'b1;
    end
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else              pcnt <= pcnt + 1'b1;
  end

  assign tick = (pcnt & div_mask(presc)) == div_mask(presc);

endmodule

// File: rtl/sclgen_deglitch.sv
module sclgen_deglitch #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] width,
  input  logic              line_in,
  output logic              sync_out,
  output logic              filt_out
);
  logic              s1, s2, q;
  logic [FILT_W-1:0] run;

  // true when this cycle completes 'w' consecutive differing cycles
  function automatic logic run_full(input logic [FILT_W-1:0] r,
                                    input logic [FILT_W-1:0] w);
    return ({1'b0, r} + 1'b1) >= {1'b0, w};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      q   <= 1'b1;
      run <= '0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      if (width == '0) begin
        q   <= s2;
        run <= '0;
      end else if (s2 == q) begin
        run <= '0;
      end else if (run_full(run, width)) begin
        q   <= s2;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  assign sync_out = s2;
  assign filt_out = (width == '0) ? s2 : q;

endmodule

// File: rtl/sclgen_sequencer.sv
module sclgen_sequencer
  import i2c_sclgen_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LO_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic                 cmd_bit,
  input  logic [SG_WORD_W-1:0] tword,
  input  logic                 scl_filt,
  input  logic                 sda_filt,
  output logic                 accept,
  output logic                 cmd_ready,
  output logic                 cmd_done,
  output logic                 scl_drv_low,
  output logic                 sda_drv_low,
  output logic                 sda_sample,
  output logic                 sample_bit,
  output logic                 ph_bit_high
);
  sg_state_e        state;
  sg_op_e           op_q, op_in;
  logic             bit_q, owned, dv_pend;
  logic [CNT_W-1:0] cnt, dv_cnt, hi_q, sh_q;
  logic [CNT_W-1:0] w_lo, w_hi, w_sh, w_dv;
  logic             unused_tword;

  function automatic logic [CNT_W-1:0] get_lo(input logic [SG_WORD_W-1:0] w);
    return CNT_W'(w[LO_W-1:0]);
  endfunction

  function automatic logic [CNT_W-1:0] get_fld(input logic [SG_WORD_W-1:0] w,
                                               input int lsb);
    return w[lsb +: CNT_W];
  endfunction

  function automatic logic last_tick(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  assign op_in  = sg_op_e'(cmd_op);
  assign w_lo   = get_lo(tword);
  assign w_hi   = get_fld(tword, SG_HI_LSB);
  assign w_sh   = get_fld(tword, SG_SH_LSB);
  assign w_dv   = get_fld(tword, SG_DV_LSB);
  assign unused_tword = ^tword[SG_HI_LSB-1:LO_W];

  assign cmd_ready   = (state == SG_IDLE);
  assign accept      = cmd_valid && cmd_ready;
  assign ph_bit_high = (state == SG_HIGH) && sg_is_bit(op_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SG_IDLE;
      op_q        <= OP_BIT;
      bit_q       <= 1'b1;
      owned       <= 1'b0;
      dv_pend     <= 1'b0;
      cnt         <= '0;
      dv_cnt      <= '0;
      hi_q        <= '0;
      sh_q        <= '0;
      scl_drv_low <= 1'b0;
      sda_drv_low <= 1'b0;
      cmd_done    <= 1'b0;
      sda_sample  <= 1'b0;
      sample_bit  <= 1'b1;
    end else begin
      cmd_done   <= 1'b0;
      sda_sample <= 1'b0;
      unique case (state)
        SG_IDLE: begin
          if (cmd_valid) begin
            op_q    <= op_in;
            bit_q   <= cmd_bit;
            hi_q    <= w_hi;
            sh_q    <= w_sh;
            dv_pend <= 1'b0;
            if (op_in == OP_START && !owned) begin
              sda_drv_low <= 1'b1;
              cnt         <= w_sh;
              state       <= SG_HOLD;
            end else begin
              cnt   <= w_lo;
              state <= SG_LOW;
              if (op_in == OP_START) begin
                sda_drv_low <= 1'b0;
              end else if (op_in == OP_STOP) begin
                sda_drv_low <= 1'b1;
              end else if (w_dv == '0) begin
                sda_drv_low <= !cmd_bit;
              end else begin
                dv_cnt  <= w_dv;
                dv_pend <= 1'b1;
              end
            end
          end
        end
        SG_LOW: begin
          if (tick) begin
            if (dv_pend && (last_tick(dv_cnt) || last_tick(cnt))) begin
              sda_drv_low <= !bit_q;
              dv_pend     <= 1'b0;
            end else if (dv_pend) begin
              dv_cnt <= dv_cnt - 1'b1;
            end
            if (last_tick(cnt)) begin
              scl_drv_low <= 1'b0;
              state       <= SG_WAIT;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        SG_WAIT: begin
          if (tick && scl_filt) begin
            state <= SG_HIGH;
            if (sg_is_bit(op_q)) begin
              cnt        <= hi_q;
              sda_sample <= 1'b1;
              sample_bit <= sda_filt;
            end else begin
              cnt <= sh_q;
            end
          end
        end
        SG_HIGH: begin
          if (tick) begin
            if (!last_tick(cnt)) begin
              cnt <= cnt - 1'b1;
            end else if (op_q == OP_START) begin
              sda_drv_low <= 1'b1;
              cnt         <= sh_q;
              state       <= SG_HOLD;
            end else if (op_q == OP_STOP) begin
              sda_drv_low <= 1'b0;
              owned       <= 1'b0;
              cmd_done    <= 1'b1;
              state       <= SG_IDLE;
            end else begin
              scl_drv_low <= 1'b1;
              cmd_done    <= 1'b1;
              state       <= SG_IDLE;
            end
          end
        end
        SG_HOLD: begin
          if (tick) begin
            if (last_tick(cnt)) begin
              scl_drv_low <= 1'b1;
              owned       <= 1'b1;
              cmd_done    <= 1'b1;
              state       <= SG_IDLE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default: state <= SG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_sclgen.sv
module i2c_sclgen
  import i2c_sclgen_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int CNT_W  = 8,
  parameter int LO_W   = 6,
  parameter int FILT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PRE_W-1:0]     presc,
  input  logic                 hs_mode,
  input  logic [SG_WORD_W-1:0] timing_std,
  input  logic [SG_WORD_W-1:0] timing_hs,
  input  logic [SG_WORD_W-1:0] filt_cfg,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic                 cmd_bit,
  output logic                 cmd_ready,
  output logic                 cmd_done,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 scl_drv_low,
  output logic                 sda_drv_low,
  output logic                 scl_filt,
  output logic                 sda_filt,
  output logic                 sda_sample,
  output logic                 sample_bit
);
  localparam int N_LINES = 2;   // index 0 = SCL, 1 = SDA

  logic                             tick, accept, ph_bit_high;
  logic [N_LINES-1:0]               line_raw, line_sync, line_filt;
  logic [N_LINES-1:0][FILT_W-1:0]   line_fw;
  logic [SG_WORD_W-1:0]             tword;
  logic                             scl_sync_w;
  logic [FILT_W-1:0]                scl_fw;
  logic                             unused_filt;

  assign tword      = hs_mode ? timing_hs : timing_std;
  assign line_raw   = {sda_in, scl_in};
  assign line_fw[0] = filt_cfg[SG_SCL_FW_LSB +: FILT_W];
  assign line_fw[1] = filt_cfg[SG_SDA_FW_LSB +: FILT_W];
  assign unused_filt = ^{filt_cfg[SG_WORD_W-1:SG_SDA_FW_LSB+FILT_W],
                         filt_cfg[SG_SDA_FW_LSB-1:SG_SCL_FW_LSB+FILT_W],
                         filt_cfg[SG_SCL_FW_LSB-1:0]};

  sclgen_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .presc   (presc),
    .tick    (tick)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    sclgen_deglitch #(.FILT_W(FILT_W)) u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .width    (line_fw[g]),
      .line_in  (line_raw[g]),
      .sync_out (line_sync[g]),
      .filt_out (line_filt[g])
    );
  end

  assign scl_filt   = line_filt[0];
  assign sda_filt   = line_filt[1];
  assign scl_sync_w = line_sync[0];
  assign scl_fw     = line_fw[0];

  sclgen_sequencer #(.CNT_W(CNT_W), .LO_W(LO_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bit     (cmd_bit),
    .tword       (tword),
    .scl_filt    (scl_filt),
    .sda_filt    (sda_filt),
    .accept      (accept),
    .cmd_ready   (cmd_ready),
    .cmd_done    (cmd_done),
    .scl_drv_low (scl_drv_low),
    .sda_drv_low (sda_drv_low),
    .sda_sample  (sda_sample),
    .sample_bit  (sample_bit),
    .ph_bit_high (ph_bit_high)
  );

endmodule

// File: rtl/i2c_sclgen_chk.sv
module i2c_sclgen_chk #(
  parameter int FILT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_done,
  input logic              sda_sample,
  input logic              scl_filt,
  input logic              scl_sync,
  input logic [FILT_W-1:0] scl_fw,
  input logic              sda_drv_low,
  input logic              ph_bit_high
);
  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  // R6: the receive strobe only fires once SCL is seen high
  a_r6_sample_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample |-> scl_filt);

  // R4: SDA is not touched during the high phase of a bit slot
  a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_bit_high && $past(ph_bit_high)) |-> $stable(sda_drv_low));

  // R10: with a nonzero width, filtered SCL only moves to the synced level
  a_r10_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fw != '0 && $past(scl_fw) != '0 && !$stable(scl_filt))
      |-> (scl_filt == $past(scl_sync)));

  // R12: acceptance takes the block out of the ready state
  a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

bind i2c_sclgen i2c_sclgen_chk #(.FILT_W(FILT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_done    (cmd_done),
  .sda_sample  (sda_sample),
  .scl_filt    (scl_filt),
  .scl_sync    (scl_sync_w),
  .scl_fw      (scl_fw),
  .sda_drv_low (sda_drv_low),
  .ph_bit_high (ph_bit_high)
);

// File: tb/i2c_sclgen_tb.sv
module i2c_sclgen_tb;
  localparam int LO = 6, HI = 5, SH = 4, DV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  presc = '0;
  logic        hs_mode = 1'b0;
  logic [31:0] timing_std, timing_hs, filt_cfg;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic        cmd_bit = 1'b1;
  logic        cmd_ready, cmd_done, scl_drv_low, sda_drv_low;
  logic        scl_filt, sda_filt, sda_sample, sample_bit;
  logic        stretch = 1'b0, slave_low = 1'b0;
  logic        scl_in, sda_in;

  int cyc = 0, acc = 0, total = 0, bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = ~scl_drv_low & ~stretch;
  assign sda_in = ~sda_drv_low & ~slave_low;

  i2c_sclgen u_dut (
    .clk(clk), .rst_n(rst_n), .presc(presc), .hs_mode(hs_mode),
    .timing_std(timing_std), .timing_hs(timing_hs), .filt_cfg(filt_cfg),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .cmd_ready(cmd_ready), .cmd_done(cmd_done),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low),
    .scl_filt(scl_filt), .sda_filt(sda_filt),
    .sda_sample(sda_sample), .sample_bit(sample_bit)
  );

  function automatic logic [31:0] tw(input int dv, input int sh, input int hi, input int lo);
    return {dv[7:0], sh[7:0], hi[7:0], lo[7:0]};
  endfunction

  function automatic logic sigsel(input int sel);
    case (sel)
      0:       return scl_drv_low;
      1:       return sda_drv_low;
      2:       return cmd_done;
      3:       return sda_sample;
      4:       return sda_filt;
      default: return scl_filt;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic b);
    int guard = 0;
    @(negedge clk);
    while (!cmd_ready && guard < 2000) begin @(negedge clk); guard++; end
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic wait_k(input int sel, input logic val, output int k);
    int guard = 0;
    while (sigsel(sel) !== val && guard < 2000) begin @(negedge clk); guard++; end
    k = cyc - acc;
  endtask

  task automatic finish_cmd();
    int k;
    wait_k(2, 1'b1, k);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "scl_drv_low", scl_drv_low, 0);
    chk("R1", "sda_drv_low", sda_drv_low, 0);
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "cmd_done", cmd_done, 0);
  endtask

  task automatic t_start_idle();
    int k;
    issue(2'b01, 1'b1);
    wait_k(1, 1'b1, k); chk("R7", "sda low at", k, 0);
    wait_k(0, 1'b1, k); chk("R7", "scl low at", k, SH);
    finish_cmd();
  endtask

  task automatic t_bit_write1();
    int k;
    issue(2'b00, 1'b1);
    wait_k(1, 1'b0, k); chk("R4", "sda release at", k, DV);
    wait_k(0, 1'b0, k); chk("R2", "scl release at", k, LO);
    wait_k(3, 1'b1, k); chk("R6", "strobe at", k, LO + 3);
    chk("R6", "sample_bit", sample_bit, 1);
    wait_k(2, 1'b1, k); chk("R5", "done at", k, LO + 3 + HI);
    chk("R5", "scl low at done", scl_drv_low, 1);
    @(negedge clk);
  endtask

  task automatic t_bit_write0();
    int k;
    issue(2'b00, 1'b0);
    wait_k(1, 1'b1, k); chk("R4", "sda low at", k, DV);
    finish_cmd();
  endtask

  task automatic t_bit_read();
    int k;
    slave_low = 1'b1;
    issue(2'b11, 1'b1);
    wait_k(3, 1'b1, k); chk("R6", "read strobe at", k, LO + 3);
    chk("R6", "sample_bit from slave", sample_bit, 0);
    finish_cmd();
    slave_low = 1'b0;
  endtask

  task automatic t_stretch(input int w);
    int k, viol, sviol;
    filt_cfg = 32'(w) << 16;
    stretch = 1'b1;
    issue(2'b00, 1'b1);
    wait_k(0, 1'b0, k); chk("R5", "stretch release at", k, LO);
    viol = 0; sviol = 0;
    for (int i = 0; i < 20; i++) begin
      if (i == 2) begin cmd_valid = 1'b1; cmd_op = 2'b10; end
      if (i == 7) cmd_valid = 1'b0;
      @(negedge clk);
      if (scl_drv_low || cmd_done || cmd_ready) viol++;
      if (sda_drv_low) sviol++;
    end
    chk("R5", "activity during stretch", viol, 0);
    chk("R12", "valid while busy changed sda", sviol, 0);
    stretch = 1'b0;
    acc = cyc;
    wait_k(2, 1'b1, k); chk(w == 0 ? "R5" : "R10", "done after stretch", k, 3 + w + HI);
    @(negedge clk);
    filt_cfg = '0;
  endtask

  task automatic t_presc();
    int k;
    presc = 3'd2;
    issue(2'b00, 1'b1);
    wait_k(0, 1'b0, k); chk("R2", "prescaled release at", k, LO * 4);
    wait_k(2, 1'b1, k); chk("R2", "prescaled done at", k, 28 + HI * 4);
    @(negedge clk);
    presc = 3'd0;
  endtask

  task automatic t_lofield();
    int k;
    timing_std = tw(DV, SH, HI, 8'hC3);
    issue(2'b00, 1'b1);
    wait_k(0, 1'b0, k); chk("R3", "upper low bits ignored", k, 3);
    finish_cmd();
    timing_std = tw(DV, SH, HI, LO);
  endtask

  task automatic t_hs();
    int k;
    hs_mode = 1'b1;
    issue(2'b00, 1'b1);
    wait_k(0, 1'b0, k); chk("R11", "hs release at", k, 10);
    finish_cmd();
    hs_mode = 1'b0;
    issue(2'b00, 1'b1);
    wait_k(0, 1'b0, k); chk("R11", "std release at", k, LO);
    finish_cmd();
  endtask

  task automatic t_rstart();
    int k;
    issue(2'b00, 1'b0);
    finish_cmd();
    issue(2'b01, 1'b1);
    wait_k(1, 1'b0, k); chk("R8", "sda release at", k, 0);
    wait_k(0, 1'b0, k); chk("R8", "scl release at", k, LO);
    wait_k(1, 1'b1, k); chk("R8", "sda low at", k, LO + 3 + SH);
    wait_k(0, 1'b1, k); chk("R8", "scl low at", k, LO + 3 + 2 * SH);
    finish_cmd();
  endtask

  task automatic t_stop();
    int k;
    issue(2'b00, 1'b1);
    finish_cmd();
    issue(2'b10, 1'b1);
    wait_k(1, 1'b1, k); chk("R9", "sda low at", k, 0);
    wait_k(0, 1'b0, k); chk("R9", "scl release at", k, LO);
    wait_k(1, 1'b0, k); chk("R9", "sda release at", k, LO + 3 + SH);
    wait_k(2, 1'b1, k); chk("R9", "done at", k, LO + 3 + SH);
    chk("R9", "scl released after stop", scl_drv_low, 0);
    @(negedge clk);
  endtask

  task automatic t_filter();
    int k, viol;
    filt_cfg = 32'd3 << 24;
    repeat (4) @(negedge clk);
    slave_low = 1'b1;
    @(negedge clk); @(negedge clk);
    slave_low = 1'b0;
    viol = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!sda_filt) viol++;
    end
    chk("R10", "short pulse seen", viol, 0);
    slave_low = 1'b1; acc = cyc;
    wait_k(4, 1'b0, k); chk("R10", "filtered fall at", k, 5);
    filt_cfg = '0;
    @(negedge clk);
    slave_low = 1'b0; acc = cyc;
    wait_k(4, 1'b1, k); chk("R10", "bypass rise at", k, 2);
  endtask

  initial begin
    timing_std = tw(DV, SH, HI, LO);
    timing_hs  = tw(DV, SH, HI, 10);
    filt_cfg   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_idle();
    t_bit_write1();
    t_bit_write0();
    t_bit_read();
    t_stretch(0);
    t_stretch(2);
    t_presc();
    t_lofield();
    t_hs();
    t_rstart();
    t_stop();
    t_filter();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule